// File: doc/BRIEF.md
# Multiword DMA Strobe Sequencer

This block paces multiword DMA bursts on a 16-bit parallel disk bus. When DMA is enabled and the attached device raises its request line, the sequencer raises the acknowledge line. It then runs a repeating three-phase word cycle: an acknowledge-to-strobe setup phase, a strobe-active phase and a recovery phase. Each pass moves one 16-bit word. In device-to-host transfers the word goes into a receive buffer. In host-to-device transfers the word comes from a transmit buffer.

The length of each phase is an 8-bit clock count. Two devices each keep their own set of three counts. A device-select input picks the set at the start of a burst. A simple write port loads a set. Before each strobe the sequencer checks the buffer flags and holds off while the needed buffer cannot take or give a word. A burst ends when the request line is found low at a phase boundary.

Top module: `mdma_timing_gen`

## Requirements
- R1: While reset is asserted, and right after it, the outputs dmack_o, rd_stb_o, wr_stb_o, dd_oe_o, tx_pop_o, rx_push_o and busy_o are all 0. An asynchronous reset during a burst clears them at once.
- R2: After reset, both devices use setup = 4, strobe = 21 and recovery = 21 clocks.
- R3: A burst starts only at a clock edge where dma_en_i and dmarq_i are both 1. dmack_o then rises at that edge. busy_o equals dmack_o at all times.
- R4: The first strobe rises max(setup,1) clocks after dmack_o rises, so a count of 0 gives 1 clock.
- R5: Each strobe stays high for max(strobe count,1) clocks.
- R6: After a strobe falls, the recovery phase lasts max(recovery count,1) clocks. The next strobe or the release follows at the end of that phase.
- R7: A cfg_we_i pulse writes cfg_tm_i, cfg_td_i and cfg_teoc_i into the set selected by cfg_dev_i. The other set is left unchanged. A burst uses the set that dev_sel_i selects at its start.
- R8: dir_tx_i = 1 (host to device) uses wr_stb_o, and 0 uses rd_stb_o. The direction is taken at burst start. The two strobes are never high together, and neither is high without dmack_o.
- R9: tx_pop_o pulses in the clock before each write strobe rises. The word on tx_data_i at that edge appears on dd_o, with dd_oe_o high, for the whole strobe.
- R10: rx_push_o pulses for one clock right after each read strobe falls. rx_data_o then carries dd_i as sampled at the edge where the strobe fell.
- R11: No write strobe starts while tx_empty_i is 1, and no read strobe starts while rx_full_i is 1. dmack_o stays high while waiting. The strobe rises at the first edge where the flag is clear.
- R12: If dmarq_i is 0 at the end of a setup or recovery phase, or while waiting on a buffer, dmack_o falls at that edge. A drop of dmarq_i during a strobe does not shorten that strobe or its recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | Allows a new burst to start |
| dir_tx_i | input | 1 | 1 = host to device, 0 = device to host |
| dev_sel_i | input | 1 | Device whose timing set the next burst uses |
| dmarq_i | input | 1 | Device DMA request |
| dmack_o | output | 1 | DMA acknowledge to the device |
| rd_stb_o | output | 1 | Read strobe, active high |
| wr_stb_o | output | 1 | Write strobe, active high |
| dd_i | input | 16 | Bus data from the device |
| dd_o | output | 16 | Bus data to the device |
| dd_oe_o | output | 1 | Bus data output enable |
| tx_empty_i | input | 1 | Transmit buffer has no word |
| tx_data_i | input | 16 | Head word of the transmit buffer |
| tx_pop_o | output | 1 | Takes the head word from the transmit buffer |
| rx_full_i | input | 1 | Receive buffer has no room |
| rx_data_o | output | 16 | Word for the receive buffer |
| rx_push_o | output | 1 | Writes rx_data_o into the receive buffer |
| busy_o | output | 1 | Transfer in progress |
| cfg_we_i | input | 1 | Write strobe for a timing set |
| cfg_dev_i | input | 1 | Timing set being written |
| cfg_tm_i | input | 8 | Setup count in clocks |
| cfg_td_i | input | 8 | Strobe count in clocks |
| cfg_teoc_i | input | 8 | Recovery count in clocks |

## Verification
The assertions take dmarq_i, the buffer flags and tx_data_i to be synchronous to clk_i. They also assume the transmit buffer only loses words through tx_pop_o. The bench drives every input on the falling edge and models the transmit buffer as a counter that advances only on a pop, so the head word stays fixed until it is taken. The receive-full flag is raised only while the sequencer is idle or waiting. Request drops are placed inside a strobe or inside a wait, which keeps each burst ending at a phase boundary that the properties describe.

// File: rtl/mdma_pkg.sv
`timescale 1ns/1ps
package mdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOV,
    ST_HOLD
  } mdma_state_e;
endpackage

// File: rtl/mdma_tset_bank.sv
`timescale 1ns/1ps
module mdma_tset_bank #(
  parameter int N_DEV    = 2,
  parameter int CNT_W    = 8,
  parameter int DEF_TM   = 4,
  parameter int DEF_TD   = 21,
  parameter int DEF_TEOC = 21,
  localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [CNT_W-1:0] tm_i,
  input  logic [CNT_W-1:0] td_i,
  input  logic [CNT_W-1:0] teoc_i,
  output logic [CNT_W-1:0] tm_o   [N_DEV],
  output logic [CNT_W-1:0] td_o   [N_DEV],
  output logic [CNT_W-1:0] teoc_o [N_DEV]
);
  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tm_o[d]   <= CNT_W'(DEF_TM);
        td_o[d]   <= CNT_W'(DEF_TD);
        teoc_o[d] <= CNT_W'(DEF_TEOC);
      end else if (we_i && (dev_i == DEV_W'(d))) begin
        tm_o[d]   <= tm_i;
        td_o[d]   <= td_i;
        teoc_o[d] <= teoc_i;
      end
    end
  end
endmodule

// File: rtl/mdma_phase_cnt.sv
`timescale 1ns/1ps
module mdma_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // a count of zero behaves as one clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/mdma_seq.sv
`timescale 1ns/1ps
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEV_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dmarq_i,
  input  logic             dir_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             tx_empty_i,
  input  logic             rx_full_i,
  input  logic             cnt_done_i,
  input  logic [CNT_W-1:0] tm_i,
  input  logic [CNT_W-1:0] td_i,
  input  logic [CNT_W-1:0] teoc_i,
  output logic [DEV_W-1:0] dev_use_o,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             dmack_o,
  output logic             rd_stb_o,
  output logic             wr_stb_o,
  output logic             tx_pop_o,
  output logic             rd_end_o
);
  mdma_state_e      state_q, state_d;
  logic             dir_q;
  logic [DEV_W-1:0] dev_q;
  logic             word_ok;
  logic             decide;

  assign word_ok = dir_q ? !tx_empty_i : !rx_full_i;
  assign decide  = ((state_q == ST_SETUP || state_q == ST_RECOV) && cnt_done_i)
                 || (state_q == ST_HOLD);

  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    len_o    = tm_i;
    tx_pop_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_i && dmarq_i) begin
          state_d = ST_SETUP;
          load_o  = 1'b1;
          len_o   = tm_i;
        end
      end
      ST_STROBE: begin
        if (cnt_done_i) begin
          state_d = ST_RECOV;
          load_o  = 1'b1;
          len_o   = teoc_i;
        end
      end
      default: begin
        if (decide) begin
          if (!dmarq_i) begin
            state_d = ST_IDLE;
          end else if (word_ok) begin
            state_d  = ST_STROBE;
            load_o   = 1'b1;
            len_o    = td_i;
            tx_pop_o = dir_q;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      dev_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d == ST_SETUP) begin
        dir_q <= dir_i;
        dev_q <= dev_i;
      end
    end
  end

  // live select while idle so the setup count of the new burst is correct
  assign dev_use_o = (state_q == ST_IDLE) ? dev_i : dev_q;
  assign dmack_o   = (state_q != ST_IDLE);
  assign rd_stb_o  = (state_q == ST_STROBE) && !dir_q;
  assign wr_stb_o  = (state_q == ST_STROBE) && dir_q;
  assign rd_end_o  = rd_stb_o && cnt_done_i;
endmodule

// File: rtl/mdma_xfer_dp.sv
`timescale 1ns/1ps
module mdma_xfer_dp #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_pop_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rd_end_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic [DATA_W-1:0] dd_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dd_o      <= '0;
      rx_data_o <= '0;
      rx_push_o <= 1'b0;
    end else begin
      if (tx_pop_i) dd_o <= tx_data_i;
      if (rd_end_i) rx_data_o <= dd_i;
      rx_push_o <= rd_end_i;
    end
  end
endmodule

// File: rtl/mdma_timing_gen.sv
`timescale 1ns/1ps
module mdma_timing_gen #(
  parameter int N_DEV    = 2,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 16,
  parameter int DEF_TM   = 4,
  parameter int DEF_TD   = 21,
  parameter int DEF_TEOC = 21,
  localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              dir_tx_i,
  input  logic [DEV_W-1:0]  dev_sel_i,
  input  logic              dmarq_i,
  output logic              dmack_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  input  logic [DATA_W-1:0] dd_i,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              busy_o,
  input  logic              cfg_we_i,
  input  logic [DEV_W-1:0]  cfg_dev_i,
  input  logic [CNT_W-1:0]  cfg_tm_i,
  input  logic [CNT_W-1:0]  cfg_td_i,
  input  logic [CNT_W-1:0]  cfg_teoc_i
);
  logic [CNT_W-1:0] tm_arr   [N_DEV];
  logic [CNT_W-1:0] td_arr   [N_DEV];
  logic [CNT_W-1:0] teoc_arr [N_DEV];
  logic [DEV_W-1:0] dev_use;
  logic             cnt_load, cnt_done, rd_end;
  logic [CNT_W-1:0] cnt_len;

  mdma_tset_bank #(
    .N_DEV(N_DEV), .CNT_W(CNT_W),
    .DEF_TM(DEF_TM), .DEF_TD(DEF_TD), .DEF_TEOC(DEF_TEOC)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .dev_i(cfg_dev_i),
    .tm_i(cfg_tm_i), .td_i(cfg_td_i), .teoc_i(cfg_teoc_i),
    .tm_o(tm_arr), .td_o(td_arr), .teoc_o(teoc_arr)
  );

  mdma_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_load), .len_i(cnt_len),
    .done_o(cnt_done)
  );

  mdma_seq #(.CNT_W(CNT_W), .DEV_W(DEV_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(dma_en_i), .dmarq_i(dmarq_i),
    .dir_i(dir_tx_i), .dev_i(dev_sel_i), .tx_empty_i(tx_empty_i),
    .rx_full_i(rx_full_i), .cnt_done_i(cnt_done),
    .tm_i(tm_arr[dev_use]), .td_i(td_arr[dev_use]), .teoc_i(teoc_arr[dev_use]),
    .dev_use_o(dev_use), .load_o(cnt_load), .len_o(cnt_len),
    .dmack_o(dmack_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
    .tx_pop_o(tx_pop_o), .rd_end_o(rd_end)
  );

  mdma_xfer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_pop_i(tx_pop_o), .tx_data_i(tx_data_i),
    .rd_end_i(rd_end), .dd_i(dd_i), .dd_o(dd_o), .rx_data_o(rx_data_o),
    .rx_push_o(rx_push_o)
  );

  assign dd_oe_o = wr_stb_o;
  assign busy_o  = dmack_o;
endmodule

// File: rtl/mdma_timing_gen_chk.sv
`timescale 1ns/1ps
module mdma_timing_gen_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dma_en_i,
  input logic              dmarq_i,
  input logic              dmack_o,
  input logic              rd_stb_o,
  input logic              wr_stb_o,
  input logic [DATA_W-1:0] dd_o,
  input logic              dd_oe_o,
  input logic              tx_empty_i,
  input logic              tx_pop_o,
  input logic              rx_full_i,
  input logic              rx_push_o
);
  assert_start_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dmack_o) |-> $past(dma_en_i && dmarq_i));

  assert_setup_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dmack_o) |-> !(rd_stb_o || wr_stb_o));

  assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));

  assert_strobe_in_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || wr_stb_o) |-> dmack_o);

  assert_pop_before_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_stb_o) |-> $past(tx_pop_o));

  assert_wr_data_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && $past(wr_stb_o)) |-> ($stable(dd_o) && dd_oe_o));

  assert_push_after_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> ($past(rd_stb_o) && !rd_stb_o));

  assert_pop_has_word_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);

  assert_rd_needs_room_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_stb_o) |-> $past(!rx_full_i));

  assert_release_on_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dmack_o) |-> $past(!dmarq_i));

  assert_strobe_not_cut_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_stb_o || wr_stb_o) |-> dmack_o);
endmodule

bind mdma_timing_gen mdma_timing_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dma_en_i(dma_en_i), .dmarq_i(dmarq_i),
  .dmack_o(dmack_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .dd_o(dd_o),
  .dd_oe_o(dd_oe_o), .tx_empty_i(tx_empty_i), .tx_pop_o(tx_pop_o),
  .rx_full_i(rx_full_i), .rx_push_o(rx_push_o)
);

// File: tb/tb_mdma_timing_gen.sv
`timescale 1ns/1ps
module tb_mdma_timing_gen;
  localparam int CW = 8;
  localparam int DW = 16;
  // {dev, dir, tm, td, teoc}
  localparam logic [25:0] VECS [6] = '{
    {1'b0, 1'b0, 8'd3,  8'd5,  8'd2},
    {1'b1, 1'b1, 8'd7,  8'd2,  8'd9},
    {1'b0, 1'b1, 8'd1,  8'd1,  8'd1},
    {1'b1, 1'b0, 8'd0,  8'd0,  8'd0},
    {1'b0, 1'b0, 8'd12, 8'd30, 8'd6},
    {1'b1, 1'b1, 8'd2,  8'd0,  8'd3}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          dma_en = 0, dir_tx = 0, dev_sel = 0, dmarq = 0, rx_full = 0;
  logic          cfg_we = 0, cfg_dev = 0;
  logic [CW-1:0] cfg_tm = 0, cfg_td = 0, cfg_teoc = 0;
  logic [DW-1:0] dd_i = '0;
  logic          dmack_o, rd_stb_o, wr_stb_o, dd_oe_o, tx_pop_o, rx_push_o, busy_o;
  logic [DW-1:0] dd_o, rx_data_o, tx_data_i;
  logic          tx_empty_i;

  int tx_pops = 0, tx_avail = 0;
  logic [DW-1:0] exp_wr = '0;
  assign tx_empty_i = (tx_pops >= tx_avail);
  assign tx_data_i  = DW'(16'h5000 + tx_pops);

  mdma_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .dma_en_i(dma_en), .dir_tx_i(dir_tx),
    .dev_sel_i(dev_sel), .dmarq_i(dmarq), .dmack_o(dmack_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .dd_i(dd_i), .dd_o(dd_o),
    .dd_oe_o(dd_oe_o), .tx_empty_i(tx_empty_i), .tx_data_i(tx_data_i),
    .tx_pop_o(tx_pop_o), .rx_full_i(rx_full), .rx_data_o(rx_data_o),
    .rx_push_o(rx_push_o), .busy_o(busy_o), .cfg_we_i(cfg_we),
    .cfg_dev_i(cfg_dev), .cfg_tm_i(cfg_tm), .cfg_td_i(cfg_td),
    .cfg_teoc_i(cfg_teoc)
  );

  int errs = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // transmit buffer model: head advances only on a pop
  always @(posedge clk) if (tx_pop_o) begin
    tx_pops <= tx_pops + 1;
    exp_wr  <= tx_data_i;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // edge recorder and device model, sampled on the falling edge
  int t_ack_r, t_stb_r, t_stb_f, t_ack_f;
  bit got_r = 0, got_f = 0;
  int rd_rises = 0, wr_rises = 0, pushes = 0;
  logic p_ack = 0, p_rd = 0, p_wr = 0;
  always @(negedge clk) begin
    if (dmack_o && !p_ack) t_ack_r = cyc;
    if ((rd_stb_o || wr_stb_o) && !(p_rd || p_wr) && !got_r) begin t_stb_r = cyc; got_r = 1; end
    if (!(rd_stb_o || wr_stb_o) && (p_rd || p_wr) && !got_f) begin t_stb_f = cyc; got_f = 1; end
    if (!dmack_o && p_ack) t_ack_f = cyc;
    if (rd_stb_o && !p_rd) rd_rises++;
    if (rd_stb_o) dd_i = DW'(16'hA000 + rd_rises);
    if (wr_stb_o && !p_wr) begin
      wr_rises++;
      chk(dd_oe_o && dd_o == exp_wr, "R9", "write word on bus", int'(dd_o), int'(exp_wr));
    end
    if (rx_push_o) begin
      pushes++;
      chk(rx_data_o == DW'(16'hA000 + pushes), "R10", "captured word", int'(rx_data_o),
          int'(DW'(16'hA000 + pushes)));
    end
    p_ack = dmack_o; p_rd = rd_stb_o; p_wr = wr_stb_o;
  end

  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic cfg(bit dev, int tm, int td, int teoc);
    @(negedge clk);
    cfg_we = 1; cfg_dev = dev; cfg_tm = CW'(tm); cfg_td = CW'(td); cfg_teoc = CW'(teoc);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (dmack_o);
    @(posedge clk);
  endtask

  // one-word burst, request dropped in the first strobe clock (R12)
  task automatic run_one(bit dev, bit dir, int etm, int etd, int eteoc, string tag);
    bit saw_wr;
    got_r = 0; got_f = 0;
    @(negedge clk);
    dev_sel = dev; dir_tx = dir; dma_en = 1; dmarq = 1; rx_full = 0;
    tx_avail = tx_pops + 1000;
    do @(negedge clk); while (!(rd_stb_o || wr_stb_o));
    saw_wr = wr_stb_o;
    dmarq = 0;
    chk(busy_o == dmack_o && busy_o, "R3", "busy during burst", int'(busy_o), 1);
    wait_idle();
    chk(saw_wr == dir, {tag, " R8"}, "strobe kind", int'(saw_wr), int'(dir));
    chk(t_stb_r - t_ack_r == etm, {tag, " R4"}, "setup clocks", t_stb_r - t_ack_r, etm);
    chk(t_stb_f - t_stb_r == etd, {tag, " R5 R12"}, "strobe clocks", t_stb_f - t_stb_r, etd);
    chk(t_ack_f - t_stb_f == eteoc, {tag, " R6"}, "recovery clocks", t_ack_f - t_stb_f, eteoc);
  endtask

  task automatic run_multi(bit dir, int n);
    int r0, p0;
    r0 = dir ? wr_rises : rd_rises;
    p0 = dir ? tx_pops : pushes;
    @(negedge clk);
    dev_sel = 0; dir_tx = dir; dma_en = 1; dmarq = 1; rx_full = 0;
    tx_avail = tx_pops + n;
    do @(negedge clk); while (((dir ? wr_rises : rd_rises) - r0) < n);
    dmarq = 0;
    wait_idle();
    @(negedge clk);
    if (dir) chk(tx_pops - p0 == n, "R9", "words popped", tx_pops - p0, n);
    else     chk(pushes - p0 == n, "R10", "words pushed", pushes - p0, n);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=150000 cycles expected=end of run");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!(dmack_o || rd_stb_o || wr_stb_o || dd_oe_o || tx_pop_o || rx_push_o || busy_o),
        "R1", "outputs in reset", int'(dmack_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!(dmack_o || rd_stb_o || wr_stb_o || dd_oe_o || tx_pop_o || rx_push_o || busy_o),
        "R1", "outputs after reset", int'(dmack_o), 0);

    // R2: reset defaults for both devices
    run_one(0, 0, 4, 21, 21, "R2");
    run_one(1, 1, 4, 21, 21, "R2");

    // table of timing sets
    for (int i = 0; i < 6; i++) begin
      logic [25:0] v;
      v = VECS[i];
      cfg(v[25], int'(v[23:16]), int'(v[15:8]), int'(v[7:0]));
      run_one(v[25], v[24], eff(int'(v[23:16])), eff(int'(v[15:8])), eff(int'(v[7:0])), "tbl");
    end

    // R7: sets are independent
    cfg(0, 3, 4, 5);
    cfg(1, 9, 9, 9);
    run_one(0, 1, 3, 4, 5, "R7");
    run_one(1, 0, 9, 9, 9, "R7");

    // R3: enable gates the start
    @(negedge clk);
    dma_en = 0; dmarq = 1;
    repeat (15) @(negedge clk);
    chk(!dmack_o && !busy_o, "R3", "no start while disabled", int'(dmack_o), 0);
    dma_en = 1;
    @(negedge clk);
    chk(dmack_o && busy_o, "R3", "start once enabled", int'(dmack_o), 1);
    dmarq = 0;
    wait_idle();

    // multiword bursts
    cfg(0, 2, 3, 2);
    run_multi(0, 3);
    run_multi(1, 3);

    // R11: write throttled by empty transmit buffer
    @(negedge clk);
    dev_sel = 0; dir_tx = 1; dma_en = 1; tx_avail = tx_pops; dmarq = 1;
    begin
      int p0;
      p0 = tx_pops;
      repeat (20) @(negedge clk);
      chk(dmack_o && !wr_stb_o && tx_pops == p0, "R11", "wait on empty", int'(wr_stb_o), 0);
    end
    tx_avail = tx_pops + 1;
    @(negedge clk);
    chk(wr_stb_o, "R11", "strobe after word arrives", int'(wr_stb_o), 1);
    dmarq = 0;
    wait_idle();

    // R11 and R12: read throttled by full receive buffer, release while waiting
    @(negedge clk);
    dir_tx = 0; rx_full = 1; dmarq = 1;
    begin
      int q0;
      q0 = pushes;
      repeat (20) @(negedge clk);
      chk(dmack_o && !rd_stb_o && pushes == q0, "R11", "wait on full", int'(rd_stb_o), 0);
    end
    dmarq = 0;
    @(negedge clk);
    chk(!dmack_o, "R12", "release while waiting", int'(dmack_o), 0);
    rx_full = 0;

    // R1: reset in the middle of a burst
    @(negedge clk);
    dir_tx = 1; tx_avail = tx_pops + 100; dmarq = 1;
    do @(negedge clk); while (!wr_stb_o);
    rst_ni = 0;
    #1;
    chk(!(dmack_o || wr_stb_o || dd_oe_o || busy_o), "R1", "async clear", int'(dmack_o), 0);
    dmarq = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!dmack_o, "R1", "idle after reset", int'(dmack_o), 0);

    summary();
    $finish;
  end
endmodule